// File: doc/BRIEF.md
# Widening Saturating Scaled Multiply-Accumulate Element

This block is the per-element arithmetic of a vector unit's widening fixed-point multiply-accumulate. It takes two source elements of SEW bits (SEW is 8, 16 or 32, fixed by a parameter) and an accumulator element of 2*SEW bits. It forms the exact product and scales it down by SEW/2 bits. A rounding increment, picked by a 2-bit rounding mode, is added to the scaled value. The scaled value is then added to the accumulator, or subtracted from it, with saturation to the 2*SEW range.

Four operation codes choose the signedness of the sources and whether the value is added or subtracted. A source code chooses whether the second operand comes from the vector source or from the low SEW bits of a scalar register value. The result, a saturation flag and an illegal-operation flag are registered, so an element issued in one cycle appears at the outputs in the next cycle. The surrounding unit ORs the saturation flag into its sticky fixed-point saturation status.

Top module: `wsm_top`

## Requirements
- R1: While reset is applied and until the first valid element is accepted, out_valid, result, sat and illegal are all zero.
- R2: out_valid is high exactly one cycle after in_valid is high. In a cycle with in_valid low, result, sat and illegal keep their previous values.
- R3: The signed product is shifted right arithmetically by SEW/2 bits. An increment is then added that depends on round_mode: 00 adds the most significant discarded bit; 01 adds 1 when the discarded bits exceed one half, or equal one half with the kept LSB odd; 10 adds nothing; 11 adds 1 when any discarded bit is set and the kept LSB is 0.
- R4: op_code 111100 treats both sources as unsigned. It adds the scaled value to the accumulator, read as unsigned, and clamps at 2^(2*SEW)-1.
- R5: op_code 111101 treats both sources as signed. It adds the scaled value to the accumulator, read as signed, and clamps to the signed 2*SEW range.
- R6: op_code 111110 treats vs2_elem as unsigned and the second operand as signed. It subtracts the scaled value from the signed accumulator with signed clamping.
- R7: op_code 111111 with src_code 100 treats vs2_elem as signed and the scalar operand as unsigned. It subtracts the scaled value from the signed accumulator with signed clamping.
- R8: src_code 000 takes the second operand from vs1_elem. src_code 100 takes it from scalar[SEW-1:0], and the higher scalar bits have no effect.
- R9: sat is 1 exactly when the result was clamped to the maximum or minimum of its range.
- R10: An op_code other than 1111xx, op_code 111111 with src_code 000, or a src_code other than 000 or 100 sets illegal to 1. In that case result equals acc_in and sat is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An element is presented this cycle |
| op_code | input | 6 | Operation select (signedness and add or subtract) |
| src_code | input | 3 | 000 vector-vector, 100 vector-scalar |
| round_mode | input | 2 | Fixed-point rounding mode |
| vs2_elem | input | SEW | First source element |
| vs1_elem | input | SEW | Second source element (vector-vector form) |
| scalar | input | XLEN | Scalar register value (vector-scalar form) |
| acc_in | input | 2*SEW | Accumulator element |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 2*SEW | Accumulated, saturated value |
| sat | output | 1 | Result was clamped |
| illegal | output | 1 | Operation code combination not supported |

## Verification
For SEW=8, each legal operation is swept over every vs2 value, for each rounding mode. The second operand takes a spread of values that includes 0, 0x7F, 0x80 and 0xFF. Because the source operands differ in sign interpretation between the modes, the sweep tells apart unsigned, signed and mixed products and add from subtract. The accumulator rotates between zero, values near both signed limits, the unsigned top and arbitrary values, so that clamps to each bound and the unclamped path are all exercised. Directed cases use exact-half and off-half discarded fractions, which tell the four rounding modes apart. Further directed cases use junk in the upper scalar bits, each illegal code combination, and idle cycles between elements.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

  localparam logic [5:0] OPC_UU = 6'b111100;
  localparam logic [5:0] OPC_SS = 6'b111101;
  localparam logic [5:0] OPC_SU = 6'b111110;
  localparam logic [5:0] OPC_US = 6'b111111;

  localparam logic [2:0] SRC_VV = 3'b000;
  localparam logic [2:0] SRC_VX = 3'b100;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'b00,
    RND_NEAR_EVEN = 2'b01,
    RND_TRUNC     = 2'b10,
    RND_JAM_ODD   = 2'b11
  } wsm_rnd_e;

  typedef struct packed {
    logic use_scalar;
    logic a_signed;
    logic b_signed;
    logic subtract;
    logic sat_signed;
    logic illegal;
  } wsm_ctrl_t;

endpackage

// File: rtl/wsm_decode.sv
module wsm_decode
  import wsm_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [2:0] src_code,
  output wsm_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (src_code)
      SRC_VV:  ctrl.use_scalar = 1'b0;
      SRC_VX:  ctrl.use_scalar = 1'b1;
      default: ctrl.illegal    = 1'b1;
    endcase
    case (op_code)
      OPC_UU: begin
        ctrl.a_signed   = 1'b0;
        ctrl.b_signed   = 1'b0;
        ctrl.subtract   = 1'b0;
        ctrl.sat_signed = 1'b0;
      end
      OPC_SS: begin
        ctrl.a_signed   = 1'b1;
        ctrl.b_signed   = 1'b1;
        ctrl.subtract   = 1'b0;
        ctrl.sat_signed = 1'b1;
      end
      OPC_SU: begin
        ctrl.a_signed   = 1'b0;
        ctrl.b_signed   = 1'b1;
        ctrl.subtract   = 1'b1;
        ctrl.sat_signed = 1'b1;
      end
      OPC_US: begin
        ctrl.a_signed   = 1'b1;
        ctrl.b_signed   = 1'b0;
        ctrl.subtract   = 1'b1;
        ctrl.sat_signed = 1'b1;
        if (src_code == SRC_VV) ctrl.illegal = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/wsm_scale.sv
module wsm_scale
  import wsm_pkg::*;
#(
  parameter int SEW = 8
) (
  input  logic [SEW-1:0]      a_elem,
  input  logic [SEW-1:0]      b_elem,
  input  logic                a_signed,
  input  logic                b_signed,
  input  wsm_rnd_e            rnd,
  output logic [2*SEW+1:0]    scaled
);

  localparam int PW = 2 * SEW + 2;
  localparam int SH = SEW / 2;

  logic        [SEW:0]  a_ext;
  logic        [SEW:0]  b_ext;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] kept;
  logic                 kept_lsb;
  logic                 half_bit;
  logic                 below_half;
  logic                 inc;

  always_comb begin
    a_ext      = {a_signed & a_elem[SEW-1], a_elem};
    b_ext      = {b_signed & b_elem[SEW-1], b_elem};
    prod       = $signed(a_ext) * $signed(b_ext);
    kept       = prod >>> SH;
    kept_lsb   = prod[SH];
    half_bit   = prod[SH-1];
    below_half = |prod[SH-2:0];
    case (rnd)
      RND_NEAR_UP:   inc = half_bit;
      RND_NEAR_EVEN: inc = half_bit & (below_half | kept_lsb);
      RND_TRUNC:     inc = 1'b0;
      RND_JAM_ODD:   inc = ~kept_lsb & (half_bit | below_half);
      default:       inc = 1'b0;
    endcase
    scaled = kept + {{(PW-1){1'b0}}, inc};
  end

endmodule

// File: rtl/wsm_satacc.sv
module wsm_satacc #(
  parameter int WW = 16
) (
  input  logic [WW-1:0] acc,
  input  logic [WW+1:0] addend,
  input  logic          subtract,
  input  logic          sat_signed,
  output logic [WW-1:0] sum_out,
  output logic          clamped
);

  localparam int SW = WW + 3;

  logic [SW-1:0] acc_ext;
  logic [SW-1:0] add_ext;
  logic [SW-1:0] sum;
  logic          neg;
  logic          hi_any;
  logic          hi_all;

  always_comb begin
    acc_ext = {{3{sat_signed & acc[WW-1]}}, acc};
    add_ext = {addend[WW+1], addend};
    sum     = subtract ? (acc_ext - add_ext) : (acc_ext + add_ext);
    neg     = sum[SW-1];
    sum_out = sum[WW-1:0];
    clamped = 1'b0;
    if (sat_signed) begin
      hi_any = |sum[SW-2:WW-1];
      hi_all = &sum[SW-2:WW-1];
      if (!neg && hi_any) begin
        sum_out = {1'b0, {(WW-1){1'b1}}};
        clamped = 1'b1;
      end else if (neg && !hi_all) begin
        sum_out = {1'b1, {(WW-1){1'b0}}};
        clamped = 1'b1;
      end
    end else begin
      hi_any = |sum[SW-2:WW];
      hi_all = 1'b0;
      if (neg) begin
        sum_out = '0;
        clamped = 1'b1;
      end else if (hi_any) begin
        sum_out = '1;
        clamped = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wsm_top.sv
module wsm_top
  import wsm_pkg::*;
#(
  parameter int SEW  = 8,
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        op_code,
  input  logic [2:0]        src_code,
  input  logic [1:0]        round_mode,
  input  logic [SEW-1:0]    vs2_elem,
  input  logic [SEW-1:0]    vs1_elem,
  input  logic [XLEN-1:0]   scalar,
  input  logic [2*SEW-1:0]  acc_in,
  output logic              out_valid,
  output logic [2*SEW-1:0]  result,
  output logic              sat,
  output logic              illegal
);

  localparam int WW = 2 * SEW;
  localparam int PW = WW + 2;

  // reset synchronizer: asserts at once, releases after two edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wsm_ctrl_t      ctrl;
  logic [SEW-1:0] b_sel;
  logic [PW-1:0]  scaled;
  logic [WW-1:0]  acc_sum;
  logic           acc_clamp;
  logic           unused_scalar_hi;

  assign unused_scalar_hi = ^scalar[XLEN-1:SEW];

  wsm_decode u_decode (
    .op_code  (op_code),
    .src_code (src_code),
    .ctrl     (ctrl)
  );

  assign b_sel = ctrl.use_scalar ? scalar[SEW-1:0] : vs1_elem;

  wsm_scale #(.SEW(SEW)) u_scale (
    .a_elem   (vs2_elem),
    .b_elem   (b_sel),
    .a_signed (ctrl.a_signed),
    .b_signed (ctrl.b_signed),
    .rnd      (wsm_rnd_e'(round_mode)),
    .scaled   (scaled)
  );

  wsm_satacc #(.WW(WW)) u_satacc (
    .acc        (acc_in),
    .addend     (scaled),
    .subtract   (ctrl.subtract),
    .sat_signed (ctrl.sat_signed),
    .sum_out    (acc_sum),
    .clamped    (acc_clamp)
  );

  logic          valid_d, valid_q;
  logic [WW-1:0] result_d, result_q;
  logic          sat_d, sat_q;
  logic          illegal_d, illegal_q;

  always_comb begin
    valid_d   = in_valid;
    illegal_d = ctrl.illegal;
    if (ctrl.illegal) begin
      result_d = acc_in;
      sat_d    = 1'b0;
    end else begin
      result_d = acc_sum;
      sat_d    = acc_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q   <= 1'b0;
      result_q  <= '0;
      sat_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        result_q  <= result_d;
        sat_q     <= sat_d;
        illegal_q <= illegal_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign sat       = sat_q;
  assign illegal   = illegal_q;

endmodule

// File: rtl/wsm_chk.sv
module wsm_chk #(
  parameter int SEW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [5:0]       op_code,
  input logic [2:0]       src_code,
  input logic [2*SEW-1:0] acc_in,
  input logic             out_valid,
  input logic [2*SEW-1:0] result,
  input logic             sat,
  input logic             illegal
);

  localparam int WW = 2 * SEW;
  localparam logic [WW-1:0] SMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] SMIN = {1'b1, {(WW-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(sat) && $stable(illegal))); // R2

  AST_BAD_CODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code[5:2] != 4'b1111) |=>
      (illegal && !sat && result == $past(acc_in))); // R10

  AST_VX_ONLY_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 6'b111111 && src_code == 3'b000) |=> illegal); // R10

  AST_NO_SAT_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !sat); // R10

  AST_UNSIGNED_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 6'b111100 && (src_code == 3'b000 || src_code == 3'b100))
      |=> (result >= $past(acc_in))); // R4

  AST_UNSIGNED_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat && $past(op_code) == 6'b111100) |-> (result == '1)); // R9

  AST_SIGNED_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sat && $past(op_code) != 6'b111100) |->
      (result == SMAX || result == SMIN)); // R9

endmodule

bind wsm_top wsm_chk #(.SEW(SEW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .op_code   (op_code),
  .src_code  (src_code),
  .acc_in    (acc_in),
  .out_valid (out_valid),
  .result    (result),
  .sat       (sat),
  .illegal   (illegal)
);

// File: tb/wsm_top_tb.sv
module wsm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEW  = 8;
  localparam int XLEN = 32;
  localparam int WW   = 2 * SEW;
  localparam int SH   = SEW / 2;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [5:0]        op_code;
  logic [2:0]        src_code;
  logic [1:0]        round_mode;
  logic [SEW-1:0]    vs2_elem;
  logic [SEW-1:0]    vs1_elem;
  logic [XLEN-1:0]   scalar;
  logic [WW-1:0]     acc_in;
  logic              out_valid;
  logic [WW-1:0]     result;
  logic              sat;
  logic              illegal;

  int checks = 0;
  int errors = 0;

  wsm_top #(.SEW(SEW), .XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_code(src_code), .round_mode(round_mode), .vs2_elem(vs2_elem),
    .vs1_elem(vs1_elem), .scalar(scalar), .acc_in(acc_in),
    .out_valid(out_valid), .result(result), .sat(sat), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint sx(input longint v, input int bits);
    return (v >= (longint'(1) << (bits - 1))) ? v - (longint'(1) << bits) : v;
  endfunction

  // op: 0 unsigned, 1 signed, 2 signed-by-unsigned, 3 unsigned-by-signed
  function automatic void model(input int op, input int rm, input longint a,
                                input longint b, input longint acc,
                                output longint res, output bit clamp);
    longint av, bv, p, q, r, half, s, t, lo, hi;
    bit inc;
    av   = (op == 1 || op == 3) ? sx(a, SEW) : a;
    bv   = (op == 1 || op == 2) ? sx(b, SEW) : b;
    p    = av * bv;
    q    = p >>> SH;
    r    = p - (q <<< SH);
    half = longint'(1) << (SH - 1);
    case (rm)
      0: inc = (r >= half);
      1: inc = (r > half) || (r == half && q[0]);
      2: inc = 1'b0;
      default: inc = (r != 0) && !q[0];
    endcase
    s = q + longint'(inc);
    if (op == 0) begin
      t = acc + s; lo = 0; hi = (longint'(1) << WW) - 1;
    end else begin
      lo = -(longint'(1) << (WW - 1)); hi = (longint'(1) << (WW - 1)) - 1;
      t = (op == 1) ? sx(acc, WW) + s : sx(acc, WW) - s;
    end
    clamp = 1'b0;
    if (t > hi) begin t = hi; clamp = 1'b1; end
    if (t < lo) begin t = lo; clamp = 1'b1; end
    res = t & ((longint'(1) << WW) - 1);
  endfunction

  task automatic expect_out(input string tag, input logic [WW-1:0] er,
                            input bit es, input bit ei, input bit ev);
    checks++;
    if (result !== er || sat !== es || illegal !== ei || out_valid !== ev) begin
      errors++;
      $display("FAIL %s: actual res=%h sat=%b ill=%b vld=%b expected res=%h sat=%b ill=%b vld=%b",
               tag, result, sat, illegal, out_valid, er, es, ei, ev);
    end
  endtask

  // drive at a falling edge, return at the falling edge after the capture
  task automatic issue(input logic [5:0] oc, input logic [2:0] sc, input logic [1:0] rm,
                       input logic [SEW-1:0] a, input logic [SEW-1:0] v1,
                       input logic [XLEN-1:0] scl, input logic [WW-1:0] acc);
    in_valid = 1'b1; op_code = oc; src_code = sc; round_mode = rm;
    vs2_elem = a; vs1_elem = v1; scalar = scl; acc_in = acc;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [5:0] OPS [4] = '{6'b111100, 6'b111101, 6'b111110, 6'b111111};

  initial begin
    longint er;
    bit es;
    int b;
    int accv;
    bit vx;
    string tag;
    logic [WW-1:0] held;

    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; src_code = '0; round_mode = '0;
    vs2_elem = '0; vs1_elem = '0; scalar = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1 reset state", '0, 1'b0, 1'b0, 1'b0);

    // R2: latency and hold while idle
    issue(6'b111100, 3'b000, 2'b10, 8'd16, 8'd16, 32'h0, 16'd1);
    expect_out("R2 first element", 16'd17, 1'b0, 1'b0, 1'b1);
    in_valid = 1'b0; vs2_elem = 8'hFF; acc_in = 16'h5555;
    @(posedge clk); @(negedge clk);
    expect_out("R2 idle holds", 16'd17, 1'b0, 1'b0, 1'b0);

    // R3: exact-half and odd-kept cases, unsigned, acc 0
    issue(6'b111100, 3'b000, 2'b00, 8'd2, 8'd4, 32'h0, 16'd0);
    expect_out("R3 tie nearest-up", 16'd1, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b000, 2'b01, 8'd2, 8'd4, 32'h0, 16'd0);
    expect_out("R3 tie nearest-even", 16'd0, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b000, 2'b10, 8'd4, 8'd6, 32'h0, 16'd0);
    expect_out("R3 truncate", 16'd1, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b000, 2'b01, 8'd4, 8'd6, 32'h0, 16'd0);
    expect_out("R3 tie even up", 16'd2, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b000, 2'b11, 8'd4, 8'd6, 32'h0, 16'd0);
    expect_out("R3 jam odd kept", 16'd1, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b000, 2'b11, 8'd2, 8'd4, 32'h0, 16'd0);
    expect_out("R3 jam even kept", 16'd1, 1'b0, 1'b0, 1'b1);

    // R8: scalar upper bits ignored
    issue(6'b111100, 3'b100, 2'b10, 8'h10, 8'h00, 32'hFFFF_FF10, 16'd0);
    expect_out("R8 scalar junk high", 16'd16, 1'b0, 1'b0, 1'b1);
    issue(6'b111100, 3'b100, 2'b10, 8'h10, 8'h00, 32'h0000_0010, 16'd0);
    expect_out("R8 scalar clean", 16'd16, 1'b0, 1'b0, 1'b1);

    // R9: clamps at both kinds of bound
    issue(6'b111100, 3'b000, 2'b00, 8'hFF, 8'hFF, 32'h0, 16'hFFFF);
    expect_out("R9 unsigned top", 16'hFFFF, 1'b1, 1'b0, 1'b1);
    issue(6'b111101, 3'b000, 2'b00, 8'h7F, 8'h7F, 32'h0, 16'h7FFF);
    expect_out("R9 signed top", 16'h7FFF, 1'b1, 1'b0, 1'b1);
    issue(6'b111110, 3'b000, 2'b10, 8'hFF, 8'h7F, 32'h0, 16'h8000);
    expect_out("R9 signed bottom", 16'h8000, 1'b1, 1'b0, 1'b1);

    // R10: illegal combinations pass the accumulator through
    issue(6'b000000, 3'b000, 2'b00, 8'h33, 8'h44, 32'h0, 16'h1234);
    expect_out("R10 unknown op", 16'h1234, 1'b0, 1'b1, 1'b1);
    issue(6'b111111, 3'b000, 2'b00, 8'h7F, 8'h7F, 32'h0, 16'hBEEF);
    expect_out("R10 vector-vector only-scalar form", 16'hBEEF, 1'b0, 1'b1, 1'b1);
    issue(6'b111101, 3'b010, 2'b00, 8'h7F, 8'h7F, 32'h0, 16'h0F0F);
    expect_out("R10 bad source code", 16'h0F0F, 1'b0, 1'b1, 1'b1);
    issue(6'b111011, 3'b100, 2'b00, 8'h7F, 8'h7F, 32'h7F, 16'h7FFF);
    expect_out("R10 near-miss op", 16'h7FFF, 1'b0, 1'b1, 1'b1);
    issue(6'b111101, 3'b000, 2'b10, 8'd16, 8'd16, 32'h0, 16'd0);
    expect_out("R10 legal after illegal", 16'd16, 1'b0, 1'b0, 1'b1);

    // sweep: every vs2 value, every mode, spread of second operands
    for (int op = 0; op < 4; op++) begin
      for (int rm = 0; rm < 4; rm++) begin
        for (int a = 0; a < 256; a++) begin
          for (int bi = 0; bi < 18; bi++) begin
            b = (bi == 16) ? 128 : (bi == 17) ? 127 : bi * 17;
            case ((a + bi) % 6)
              0: accv = 0;
              1: accv = 16'h7FF0;
              2: accv = 16'h8008;
              3: accv = 16'hFFF8;
              4: accv = 16'h0100;
              default: accv = (a * 31 + bi * 1237) & 16'hFFFF;
            endcase
            vx = (op == 3) || (a % 2 == 1);
            case (op)
              0: tag = "R4 R3 R9 unsigned sweep";
              1: tag = "R5 R3 R9 signed sweep";
              2: tag = "R6 R3 R8 R9 signed-by-unsigned sweep";
              default: tag = "R7 R3 R8 R9 unsigned-by-signed sweep";
            endcase
            model(op, rm, a, b, accv, er, es);
            if (vx)
              issue(OPS[op], 3'b100, rm[1:0], a[7:0], ~b[7:0],
                    {24'hA5C3E1, b[7:0]}, accv[15:0]);
            else
              issue(OPS[op], 3'b000, rm[1:0], a[7:0], b[7:0],
                    {24'h5A3C1E, ~b[7:0]}, accv[15:0]);
            expect_out(tag, er[15:0], es, 1'b0, 1'b1);
          end
        end
      end
    end

    in_valid = 1'b0;
    held = result;
    @(posedge clk); @(negedge clk);
    expect_out("R2 final idle", held, sat, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule